// File: doc/BRIEF.md
# Thermal Trip-Point Comparator with Hysteresis

This block keeps an upper trip limit and a lower release limit, both 16-bit two's-complement words laid out like the temperature sample: bit 15 is the sign, bit 14 is the top magnitude bit, and one LSB at 12-bit resolution equals 1/16 degree. Each time a new sample is strobed in, the block compares it against both limits and updates an over-temperature flag. The flag rises at or above the upper limit. It falls only after the temperature drops strictly below the release limit. Between the two limits the flag holds its last value.

A 2-bit resolution code selects how many leading bits of the sample and of both limits take part in the compare. The lowest four bits of each limit are not stored and always read back as zero. After reset the limits hold 80 and 75 degrees.

Top module: `thermal_trip`

## Requirements
- R1: Reset clears the alarm and loads the upper limit with 16'h5000 and the release limit with 16'h4B00.
- R2: A write strobe loads its limit with the write data on the next clock. Bits 3:0 of both limits always read as zero, whatever was written.
- R3: The resolution code picks the compared field. Code 0 compares bits 15:7, code 1 bits 15:6, code 2 bits 15:5 and code 3 bits 15:4. All lower bits of the sample and of both limits are cleared before the compare.
- R4: On a cycle with the sample strobe high, the alarm is set from the next clock if the masked sample is greater than or equal to the masked upper limit.
- R5: When the alarm is set, it clears on the next clock only for a strobed masked sample that is strictly below the masked release limit. Otherwise it stays set.
- R6: All compares are signed two's-complement. A negative sample never reaches a positive limit.
- R7: When the sample strobe is low, the alarm keeps its value, whatever the sample input does.
- R8: Limit bits below the active resolution have no effect on the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Sample strobe |
| smp_temp | input | 16 | Temperature sample, two's-complement |
| res_sel | input | 2 | Resolution code (0 to 3 for 9 to 12 bits) |
| hi_we | input | 1 | Upper limit write enable |
| lo_we | input | 1 | Release limit write enable |
| lim_wdata | input | 16 | Limit write data |
| hi_lim | output | 16 | Stored upper limit |
| lo_lim | output | 16 | Stored release limit |
| alarm | output | 1 | Over-temperature flag |

## Verification
A wrong limit register shows up at once on its readback port, one clock after the write. It also shows up as an alarm that trips or releases at the wrong sample. A wrong mask or a compare done without sign shows up on the first strobed sample that lands between the true threshold and the wrong one. The bench sweeps samples on a grid across both thresholds at every resolution, and places samples just above and just below each masked boundary. A lost hysteresis state shows up on the next strobe inside the band between the two limits, when the alarm takes a value different from the one the bench holds.

// File: rtl/thermal_trip.sv
module thermal_trip #(
  parameter int W = 16,
  parameter int PAD = 4,
  parameter logic [W-1:0] HI_RST = 16'h5000,
  parameter logic [W-1:0] LO_RST = 16'h4B00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_vld,
  input  logic [W-1:0] smp_temp,
  input  logic [1:0]   res_sel,
  input  logic         hi_we,
  input  logic         lo_we,
  input  logic [W-1:0] lim_wdata,
  output logic [W-1:0] hi_lim,
  output logic [W-1:0] lo_lim,
  output logic         alarm
);
  localparam int SW = W - PAD;

  logic [SW-1:0] hi_q, lo_q;
  logic [W-1:0]  mask;
  logic signed [W-1:0] s_m, hi_m, lo_m;
  logic trip, release_c;

  assign hi_lim = {hi_q, {PAD{1'b0}}};
  assign lo_lim = {lo_q, {PAD{1'b0}}};

  // keep bits 15:(7-res_sel)
  assign mask = {W{1'b1}} << (PAD + 3 - int'(res_sel));

  assign s_m  = $signed(smp_temp & mask);
  assign hi_m = $signed(hi_lim & mask);
  assign lo_m = $signed(lo_lim & mask);

  assign trip      = s_m >= hi_m;
  assign release_c = s_m < lo_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= HI_RST[W-1:PAD];
      lo_q <= LO_RST[W-1:PAD];
    end else begin
      if (hi_we) hi_q <= lim_wdata[W-1:PAD];
      if (lo_we) lo_q <= lim_wdata[W-1:PAD];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      alarm <= 1'b0;
    else if (smp_vld) begin
      if (trip)
        alarm <= 1'b1;
      else if (release_c)
        alarm <= 1'b0;
    end
  end

  AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hi_lim[PAD-1:0] == '0 && lo_lim[PAD-1:0] == '0); // R2
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    hi_we |=> hi_lim[W-1:PAD] == $past(lim_wdata[W-1:PAD])); // R2
  AST_TRIP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && trip) |=> alarm); // R4
  AST_HOLD_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && smp_vld && !release_c) |=> alarm); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(alarm)); // R7
  AST_NEG_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && smp_temp[W-1] && !hi_lim[W-1] && !alarm) |=> !alarm); // R6
endmodule

// File: tb/sim_thermal_trip.sv
module sim_thermal_trip;
  logic clk = 0, rst_n = 0, smp_vld = 0, hi_we = 0, lo_we = 0;
  logic [15:0] smp_temp = 0, lim_wdata = 0;
  logic [1:0] res_sel = 0;
  logic [15:0] hi_lim, lo_lim;
  logic alarm;
  int errs = 0, checks = 0;
  logic exp_al = 0;
  logic [15:0] e_hi = 16'h5000, e_lo = 16'h4B00;

  always #10 clk = ~clk;

  thermal_trip u0 (.clk, .rst_n, .smp_vld, .smp_temp, .res_sel, .hi_we, .lo_we,
                   .lim_wdata, .hi_lim, .lo_lim, .alarm);

  initial begin
    #5_000_000;
    errs++; checks++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] msk(logic [1:0] r);
    return 16'hFFFF << (7 - r);
  endfunction

  task automatic wr(bit hi, logic [15:0] d);
    @(negedge clk);
    lim_wdata = d; hi_we = hi; lo_we = !hi;
    @(negedge clk);
    hi_we = 0; lo_we = 0;
    if (hi) e_hi = d & 16'hFFF0; else e_lo = d & 16'hFFF0;
  endtask

  task automatic sample(logic [15:0] t, string req);
    logic signed [15:0] s, h, l;
    @(negedge clk);
    smp_temp = t; smp_vld = 1;
    s = $signed(t & msk(res_sel));
    h = $signed(e_hi & msk(res_sel));
    l = $signed(e_lo & msk(res_sel));
    if (s >= h) exp_al = 1; else if (s < l) exp_al = 0;
    @(negedge clk);
    smp_vld = 0;
    chk(req, alarm, exp_al);
  endtask

  initial begin
    #35;
    chk("R1 alarm", alarm, 0);
    chk("R1 hi", hi_lim, 16'h5000);
    chk("R1 lo", lo_lim, 16'h4B00);
    rst_n = 1;
    // R2 write and low nibble
    wr(1, 16'h123F); chk("R2 hi", hi_lim, 16'h1230);
    wr(0, 16'hF00F); chk("R2 lo", lo_lim, 16'hF000);
    wr(1, 16'h5000); wr(0, 16'h4B00);
    // R3/R4/R5 sweep across thresholds at every resolution
    for (int r = 0; r < 4; r++) begin
      res_sel = r[1:0];
      for (int t = 16'h4800; t <= 16'h5200; t += 16'h30) sample(t[15:0], "R4");
      for (int t = 16'h5200; t >= 16'h4800; t -= 16'h30) sample(t[15:0], "R5");
    end
    // R3 masked boundary: limit 0x5070 with fine bits
    wr(1, 16'h5070); wr(0, 16'h4B70);
    for (int r = 0; r < 4; r++) begin
      res_sel = r[1:0];
      sample(16'h4000, "R3");
      sample(16'h5000, "R3 edge");
      sample(16'h4B70, "R3 band");
      sample(16'h4B00, "R3 lo");
      sample(16'h4AF0, "R3 below");
    end
    // R8: low limit bits ignored at 9-bit
    res_sel = 0;
    wr(1, 16'h507F);
    sample(16'h5000, "R8");
    chk("R8 trips", alarm, 1);
    // R7: idle cycles do not move alarm
    @(negedge clk); smp_temp = 16'h8000;
    repeat (3) @(negedge clk);
    chk("R7 idle", alarm, 1);
    // R6: negative samples vs positive limit
    sample(16'hC000, "R6 clear");
    chk("R6 low", alarm, 0);
    sample(16'hFFF0, "R6 neg");
    sample(16'h8000, "R6 min");
    wr(1, 16'hFE00); wr(0, 16'hFC00);
    for (int t = 16'hF800; t <= 16'hFFF0; t += 16'h70) sample(t[15:0], "R6 sweep");
    sample(16'h7FF0, "R6 max");
    sample(16'h8000, "R6 min2");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule